// File: doc/BRIEF.md
# Trigger debounce and play-mode controller

This block serves one active-high trigger input of a word-sequence speech player. It filters the raw trigger with a debounce counter that advances on a sample-rate tick. It then turns the filtered level into start and stop commands for the player, and it tells the player which sentence to begin.

Three per-input mode bits decide how a press is interpreted. Edge or level mode decides whether one press plays the sentence once or the sentence repeats while the key is held. Hold or unhold mode decides whether releasing the key cuts playback short. Retrigger or irretrigger mode decides whether a new press during playback restarts the sentence.

An optional looping setting plays sentence 1 once and then repeats sentence 2. A force option can switch the input to slow debounce and retrigger behaviour while the player is busy. This gives a fast, irretriggerable first press and a slow, retriggerable second press.

Top module: `trig_play_ctrl`

## Requirements
- R1: During and after reset, `start_o`, `stop_o`, `sent_sel_o` and `deb_o` are all 0.
- R2: `deb_o` changes only on a cycle where `tick_i` is 1. It takes the level of `trig_i` after SLOW_TICKS consecutive ticks at the new level when the effective debounce is slow (`slow_deb_i`=1), or after FAST_TICKS ticks when it is fast. A tick at the old level restarts the count, and cycles without a tick neither advance nor restart it.
- R3: In edge mode (`level_mode_i`=0), a rising edge of `deb_o` while idle gives one `start_o` pulse with `sent_sel_o`=0. An `eos_i` pulse ends playback without a new start, even if the trigger is still high.
- R4: In level mode (`level_mode_i`=1), `eos_i` while `deb_o` is 1 gives a new `start_o` for the same sentence. `eos_i` while `deb_o` is 0 ends playback.
- R5: In hold mode (`hold_mode_i`=1), a falling edge of `deb_o` during playback gives one `stop_o` pulse and ends playback.
- R6: In unhold mode (`hold_mode_i`=0), releasing the trigger gives no `stop_o`, and playback continues until `eos_i`.
- R7: In effective retrigger mode, a rising edge of `deb_o` during playback gives `start_o` with `sent_sel_o`=0.
- R8: In effective irretrigger mode (`retrig_mode_i`=0), a rising edge of `deb_o` during playback gives no `start_o`.
- R9: With `loop_en_i`=1, `eos_i` during playback gives `start_o` with `sent_sel_o`=1 (sentence 2), whatever the trigger level. `sent_sel_o`=0 selects sentence 1.
- R10: An internal force flag is set on every cycle with `busy_i`=0. While busy, `frc_clr_i` clears it. With `frc_en_i`=1, `busy_i`=1 and the flag at 0, the input behaves as slow debounce and retrigger. Otherwise the configured `slow_deb_i` and `retrig_mode_i` apply.
- R11: `start_o` and `stop_o` are never 1 together. A hold-mode release in the same cycle as `eos_i` gives only `stop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-rate tick, one cycle wide |
| trig_i | input | 1 | Raw trigger, active high |
| level_mode_i | input | 1 | 1 = level mode, 0 = edge mode |
| hold_mode_i | input | 1 | 1 = hold mode, 0 = unhold mode |
| retrig_mode_i | input | 1 | 1 = retrigger, 0 = irretrigger |
| slow_deb_i | input | 1 | 1 = slow debounce, 0 = fast debounce |
| loop_en_i | input | 1 | 1 = sentence looping enabled |
| frc_en_i | input | 1 | Enables the force-retrigger option |
| frc_clr_i | input | 1 | Player pulse that lowers the force flag while busy |
| busy_i | input | 1 | Player is playing |
| eos_i | input | 1 | Player reached the end of the current sentence |
| start_o | output | 1 | Pulse: begin the selected sentence at its first word |
| stop_o | output | 1 | Pulse: stop playback now |
| sent_sel_o | output | 1 | Sentence for the start: 0 = sentence 1, 1 = sentence 2 |
| deb_o | output | 1 | Debounced trigger level |

## Verification
The bench builds the block with SLOW_TICKS=4 and FAST_TICKS=1. At these values a slow window fits in a handful of cycles, and a two-cycle glitch passes the fast filter but not the slow one. This makes it affordable to sweep all 32 combinations of edge/level, hold/unhold, retrigger/irretrigger, looping and debounce speed through one fixed press, release and end-of-sentence script. The expected start counts, stop counts and sentence selections are derived as formulas of the mode bits. Directed runs then check the exact tick at which a slow window closes, the force flag's glitch rejection, and the stop-over-start priority.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_PLAY = 1'b1} tpc_state_e;
endpackage

// File: rtl/tpc_debounce.sv
module tpc_debounce #(
  parameter int SLOW_TICKS = 96,
  parameter int FAST_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  input  logic slow_i,
  output logic level_o
);
  localparam int CW = $clog2(SLOW_TICKS + 1);
  localparam logic [CW:0] SLOW_C = (CW+1)'(SLOW_TICKS);
  localparam logic [CW:0] FAST_C = (CW+1)'(FAST_TICKS);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;
  logic [CW:0]   thr;
  logic          lvl_q;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign thr     = slow_i ? SLOW_C : FAST_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (tick_i) begin
      if (raw_i != lvl_q) begin
        if (cnt_inc >= thr) begin
          lvl_q <= raw_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_inc[CW-1:0];
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/tpc_force.sv
module tpc_force (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic force_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b1;
    else if (!busy_i) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  // flag low while busy: slow debounce and retrigger
  assign force_o = en_i & busy_i & ~flag_q;
endmodule

// File: rtl/tpc_seq.sv
module tpc_seq
  import tpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic deb_i,
  input  logic level_i,
  input  logic hold_i,
  input  logic retrig_i,
  input  logic loop_i,
  input  logic eos_i,
  output logic start_o,
  output logic stop_o,
  output logic sel_o
);
  tpc_state_e st_q, st_d;
  logic deb_d_q, rise, fall;
  logic start_d, stop_d, sel_d, sel_q, start_q, stop_q;

  assign rise = deb_i & ~deb_d_q;
  assign fall = ~deb_i & deb_d_q;

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    sel_d   = sel_q;
    unique case (st_q)
      ST_IDLE: begin
        if (rise) begin
          start_d = 1'b1;
          sel_d   = 1'b0;
          st_d    = ST_PLAY;
        end
      end
      ST_PLAY: begin
        if (hold_i && fall) begin
          stop_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (rise && retrig_i) begin
          start_d = 1'b1;
          sel_d   = 1'b0;
        end else if (eos_i) begin
          if (loop_i) begin
            start_d = 1'b1;
            sel_d   = 1'b1;
          end else if (level_i && deb_i) begin
            start_d = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      deb_d_q <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      deb_d_q <= deb_i;
      start_q <= start_d;
      stop_q  <= stop_d;
      sel_q   <= sel_d;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/trig_play_ctrl.sv
module trig_play_ctrl #(
  parameter int SLOW_TICKS = 96,
  parameter int FAST_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  input  logic level_mode_i,
  input  logic hold_mode_i,
  input  logic retrig_mode_i,
  input  logic slow_deb_i,
  input  logic loop_en_i,
  input  logic frc_en_i,
  input  logic frc_clr_i,
  input  logic busy_i,
  input  logic eos_i,
  output logic start_o,
  output logic stop_o,
  output logic sent_sel_o,
  output logic deb_o
);
  logic frc, slow_eff, retrig_eff;

  tpc_force u_force (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (frc_en_i),
    .busy_i  (busy_i),
    .clr_i   (frc_clr_i),
    .force_o (frc)
  );

  assign slow_eff   = slow_deb_i | frc;
  assign retrig_eff = retrig_mode_i | frc;

  tpc_debounce #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .raw_i   (trig_i),
    .slow_i  (slow_eff),
    .level_o (deb_o)
  );

  tpc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .deb_i    (deb_o),
    .level_i  (level_mode_i),
    .hold_i   (hold_mode_i),
    .retrig_i (retrig_eff),
    .loop_i   (loop_en_i),
    .eos_i    (eos_i),
    .start_o  (start_o),
    .stop_o   (stop_o),
    .sel_o    (sent_sel_o)
  );
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic trig_i,
  input logic hold_mode_i,
  input logic loop_en_i,
  input logic start_o,
  input logic stop_o,
  input logic sent_sel_o,
  input logic deb_o
);
  // R11
  a_r11_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  // R5
  a_r5_stop_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> $past(hold_mode_i));
  // R2
  a_r2_deb_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(deb_o) |-> $past(tick_i));
  // R2
  a_r2_deb_follows_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(deb_o) |-> (deb_o == $past(trig_i)));
  // R9
  a_r9_sent2_needs_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && sent_sel_o) |-> $past(loop_en_i));
endmodule

bind trig_play_ctrl tpc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .trig_i      (trig_i),
  .hold_mode_i (hold_mode_i),
  .loop_en_i   (loop_en_i),
  .start_o     (start_o),
  .stop_o      (stop_o),
  .sent_sel_o  (sent_sel_o),
  .deb_o       (deb_o)
);

// File: tb/tb_trig_play_ctrl.sv
`timescale 1ns/1ps
module tb_trig_play_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick, trig, lvl, hold, ret, slw, lp, fen, fclr, busy, eos;
  logic start_o, stop_o, sent_sel_o, deb_o;
  int n_chk = 0, n_err = 0, n_start = 0, n_stop = 0, last_sel = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trig_play_ctrl #(.SLOW_TICKS(4), .FAST_TICKS(1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .trig_i(trig),
    .level_mode_i(lvl), .hold_mode_i(hold), .retrig_mode_i(ret),
    .slow_deb_i(slw), .loop_en_i(lp), .frc_en_i(fen), .frc_clr_i(fclr),
    .busy_i(busy), .eos_i(eos), .start_o(start_o), .stop_o(stop_o),
    .sent_sel_o(sent_sel_o), .deb_o(deb_o)
  );

  always @(negedge clk) begin
    if (!rst_ni) begin
      n_start <= 0; n_stop <= 0; last_sel <= 0;
    end else begin
      if (start_o) begin n_start <= n_start + 1; last_sel <= int'(sent_sel_o); end
      if (stop_o) n_stop <= n_stop + 1;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; step(2); rst_ni = 1'b1; step(2);
  endtask

  task automatic pulse_eos();
    eos = 1'b1; step(1); eos = 1'b0; step(3);
  endtask

  task automatic tick_once();
    tick = 1'b1; step(1); tick = 1'b0; step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    tick = 1; trig = 0; lvl = 0; hold = 0; ret = 0; slw = 0; lp = 0;
    fen = 0; fclr = 0; busy = 0; eos = 0;
    step(2);
    // R1 reset state
    check("R1 start_o", int'(start_o), 0);
    check("R1 stop_o", int'(stop_o), 0);
    check("R1 sent_sel_o", int'(sent_sel_o), 0);
    check("R1 deb_o", int'(deb_o), 0);
    rst_ni = 1'b1; step(2);

    // mode sweep
    for (int c = 0; c < 32; c++) begin
      int p3, stop4, p4, start5, stop6, p6, start6, sel3, e_start, e_stop, e_sel, s_before;
      lvl = c[0]; hold = c[1]; ret = c[2]; lp = c[3]; slw = c[4];
      trig = 0; do_reset();
      trig = 1; step(10);
      check("R3 first press start", n_start, 1);
      pulse_eos();
      trig = 0; step(10);
      s_before = n_start;
      trig = 1; step(10);
      p3 = lp | lvl;
      stop4 = hold & p3;
      p4 = p3 & ~hold;
      start5 = (~p4 & 1) | ret;
      check(ret ? "R7 press in play" : "R8 press in play", n_start - s_before, start5);
      trig = 0; step(10);
      pulse_eos();
      stop6 = hold;
      p6 = ~hold & 1;
      start6 = p6 & lp;
      sel3 = lp;
      e_start = 1 + p3 + start5 + start6;
      e_stop = stop4 + stop6;
      e_sel = start6 ? 1 : (start5 ? 0 : sel3);
      check(lvl ? "R4 starts" : "R3 starts", n_start, e_start);
      check(hold ? "R5 stops" : "R6 stops", n_stop, e_stop);
      check("R9 sentence select", last_sel, e_sel);
    end

    // R2 exact slow window with gated ticks
    lvl = 0; hold = 0; ret = 0; lp = 0; slw = 1;
    tick = 0; trig = 0; do_reset();
    trig = 1; step(20);
    check("R2 no tick no change", int'(deb_o), 0);
    tick_once(); tick_once(); tick_once();
    check("R2 three ticks", int'(deb_o), 0);
    trig = 0; tick_once(); trig = 1;
    tick_once(); tick_once(); tick_once();
    check("R2 restart after old level", int'(deb_o), 0);
    tick_once();
    check("R2 fourth tick", int'(deb_o), 1);
    step(3);
    check("R3 start after debounce", n_start, 1);
    slw = 0; trig = 0; tick_once();
    check("R2 fast one tick", int'(deb_o), 0);
    tick = 1;

    // R10 force flag
    lvl = 0; hold = 0; ret = 0; lp = 0; slw = 0; fen = 1; busy = 0;
    trig = 0; do_reset();
    trig = 1; step(8); busy = 1; trig = 0; step(8);
    check("R10 first press", n_start, 1);
    trig = 1; step(2); trig = 0; step(8);
    check("R10 flag high keeps irretrigger", n_start, 1);
    fclr = 1; step(1); fclr = 0; step(2);
    trig = 1; step(2); trig = 0; step(8);
    check("R10 forced slow rejects glitch", n_start, 1);
    trig = 1; step(10);
    check("R10 forced retrigger", n_start, 2);
    check("R10 retrigger sentence", last_sel, 0);
    trig = 0; step(8); busy = 0; pulse_eos();
    busy = 1; trig = 1; step(2); trig = 0; step(8);
    check("R10 flag set again when idle", n_start, 3);
    fen = 0; busy = 0;

    // R11 hold release coinciding with eos
    lvl = 0; hold = 1; ret = 0; lp = 1; slw = 0;
    trig = 0; do_reset();
    trig = 1; step(8);
    trig = 0; step(1); eos = 1; step(1); eos = 0; step(4);
    check("R11 stop wins", n_stop, 1);
    check("R11 no start with stop", n_start, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule